// File: doc/BRIEF.md
# Stipple Fill Engine

The engine draws into a local 8-bit-per-pixel store using 64-bit stipple commands. A host presents one command word together with a pixel address. The address picks a 32-pixel span that always starts on a 32-pixel boundary. The word carries a raster operation code, a colour index, a plane selector and a 32-bit pixel mask. For each set mask bit, the engine writes the colour index into the matching pixel of the span. Pixels whose mask bit is clear keep their old value.

The host uses a ready/busy handshake. A command is taken when `cmdValid` is high in a cycle where `cmdReady` is high. A copy command then keeps the engine busy while it walks the span one pixel per clock, starting at the leftmost pixel. Other operation codes cause no writes and only a one-cycle busy pulse. Drawing that crosses a span boundary needs two commands. A screen clear is a run of commands with full masks. The pixel store has a combinational read port for the host.

Top module: `stip_fill`

## Requirements
- R1: After reset, `busy` is 0, `cmdReady` is 1 and every pixel of the store reads 0.
- R2: `cmdReady` is high exactly when `busy` is low. A command is accepted on a rising clock edge where `cmdValid` and `cmdReady` are both high.
- R3: The low 5 bits of `cmdAddr` are ignored. The span covers pixels base to base+31, where base is `cmdAddr` with its low 5 bits cleared.
- R4: When command bits 63:60 equal 4'h3 (copy), the colour index in bits 39:32 is written to every pixel of the span whose mask bit is set.
- R5: The mask is command bits 31:0. Bit 31 selects pixel base+0 (leftmost) and bit 0 selects pixel base+31.
- R6: Pixels whose mask bit is 0, and all pixels outside the span, keep their previous value.
- R7: A copy command holds `busy` high for exactly 32 cycles after the accepting edge. It writes pixel base+k at the (k+1)-th rising edge after acceptance.
- R8: Any other value of bits 63:60 writes no pixel and holds `busy` high for exactly one cycle.
- R9: A command presented while `busy` is high is ignored. It neither changes the store nor lengthens the busy period.
- R10: The plane selector (bits 57:56) and the unused bits 59:58 and 55:40 have no effect on the result.
- R11: A copy with an all-ones mask fills all 32 pixels of the span with the colour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Host presents a command |
| cmdReady | output | 1 | Engine can take a command |
| cmdAddr | input | ADDR_W (10) | Pixel address of the span |
| cmdData | input | 64 | Stipple command word |
| busy | output | 1 | Engine is working on a command |
| rdAddr | input | ADDR_W (10) | Pixel read address |
| rdData | output | PIX_W (8) | Pixel value at `rdAddr` |

## Verification
The in-RTL assertions check the sequencing on every cycle:
- the pixel index steps by one within a span and starts from zero;
- a no-op command lasts one cycle;
- acceptance happens only while idle;
- every pixel write lands inside the latched span and follows an accepted command.

Only the bench scenarios can show the pixel contents:
- that mask bit order maps to the correct pixels;
- that clear bits and the plane field leave the store untouched;
- that writes appear at the stated edges part way through a span;
- that commands arriving while busy are dropped.

Those are compared against a behavioural model of the whole store.

// File: rtl/stip_pkg.sv
package stip_pkg;
  localparam int SPAN_LEN = 32;
  localparam int IDX_W    = $clog2(SPAN_LEN);
  localparam int CMD_W    = 64;

  // command word field positions
  localparam int ROP_HI   = 63;
  localparam int ROP_LO   = 60;
  localparam int COL_HI   = 39;
  localparam int COL_LO   = 32;
  localparam int MASK_HI  = 31;
  localparam logic [3:0] ROP_COPY = 4'h3;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_NOP} seqState_e;

  typedef struct packed {
    logic             load;   // latch the command now
    logic             wr;     // write slot for pixel idx
    logic [IDX_W-1:0] idx;    // pixel position within span
  } seqStrobe_t;
endpackage

// File: rtl/stip_ctrl.sv
module stip_ctrl
  import stip_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdIsCopy,
  output logic       busy,
  output logic       cmdReady,
  output seqStrobe_t strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SPAN_LEN - 1);

  seqState_e        state;
  logic [IDX_W-1:0] pixIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      pixIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmdValid) begin
          state  <= cmdIsCopy ? ST_FILL : ST_NOP;
          pixIdx <= '0;
        end
        ST_FILL: begin
          pixIdx <= pixIdx + 1'b1;
          if (pixIdx == LAST_IDX) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (state != ST_IDLE);
    cmdReady    = (state == ST_IDLE);
    strobe.load = cmdValid && (state == ST_IDLE);
    strobe.wr   = (state == ST_FILL);
    strobe.idx  = pixIdx;
  end

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && pixIdx != LAST_IDX) |=> (state == ST_FILL && pixIdx == $past(pixIdx) + 1'b1));
  // R7
  fill_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && cmdIsCopy) |=> (state == ST_FILL && pixIdx == '0));
  // R8
  nop_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NOP) |=> (state == ST_IDLE));
  // R7
  fill_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && pixIdx == LAST_IDX) |=> !busy);
endmodule

// File: rtl/stip_datapath.sv
module stip_datapath
  import stip_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int MEM_DEPTH = 1024,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CMD_W-1:0]  cmdData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              cmdIsCopy,
  output logic [PIX_W-1:0]  rdData
);
  localparam int SPAN_W = ADDR_W - IDX_W;

  logic [SPAN_W-1:0]   spanSel;
  logic [PIX_W-1:0]    colour;
  logic [SPAN_LEN-1:0] mask;
  logic [PIX_W-1:0]    pixMem [MEM_DEPTH];

  logic [ADDR_W-1:0]   wrAddr;
  logic [IDX_W-1:0]    bitSel;
  logic                wrHit;

  assign cmdIsCopy = (cmdData[ROP_HI:ROP_LO] == ROP_COPY);
  assign bitSel    = IDX_W'(SPAN_LEN - 1) - strobe.idx;
  assign wrAddr    = {spanSel, strobe.idx};
  assign wrHit     = strobe.wr && mask[bitSel];
  assign rdData    = pixMem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spanSel <= '0;
      colour  <= '0;
      mask    <= '0;
    end else if (strobe.load) begin
      spanSel <= cmdAddr[ADDR_W-1:IDX_W];
      colour  <= cmdData[COL_LO +: PIX_W];
      mask    <= cmdData[MASK_HI -: SPAN_LEN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) pixMem[i] <= '0;
    end else if (wrHit) begin
      pixMem[wrAddr] <= colour;
    end
  end

  // R9
  load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !busy);
  // R4
  wr_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr |-> ($past(strobe.wr) || $past(strobe.load)));
  // R3
  span_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && $past(strobe.wr)) |-> $stable(spanSel));
endmodule

// File: rtl/stip_fill.sv
module stip_fill
  import stip_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int MEM_DEPTH = 1024,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CMD_W-1:0]  cmdData,
  output logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PIX_W-1:0]  rdData
);
  seqStrobe_t strobe;
  logic       cmdIsCopy;

  stip_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdIsCopy(cmdIsCopy),
    .busy     (busy),
    .cmdReady (cmdReady),
    .strobe   (strobe)
  );

  stip_datapath #(.PIX_W(PIX_W), .MEM_DEPTH(MEM_DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busy     (busy),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .rdAddr   (rdAddr),
    .cmdIsCopy(cmdIsCopy),
    .rdData   (rdData)
  );
endmodule

// File: tb/stip_fill_tb.sv
`timescale 1ns/1ps
module stip_fill_tb;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic          clk = 0;
  logic          rstN = 0;
  logic          cmdValid = 0;
  logic          cmdReady, busy;
  logic [AW-1:0] cmdAddr = '0;
  logic [63:0]   cmdData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    rdData;

  int vecCnt = 0;
  int errCnt = 0;
  logic [7:0] refMem [DEPTH];

  always #2 clk = ~clk;

  stip_fill u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .busy(busy),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [63:0] mkCmd(logic [3:0] rop, logic [1:0] plane,
                                        logic [7:0] col, logic [31:0] msk,
                                        logic [1:0] junkA, logic [15:0] junkB);
    return {rop, junkA, plane, junkB, col, msk};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmpAll(string req);
    for (int a = 0; a < DEPTH; a++) begin
      rdAddr = AW'(a);
      #0.001;
      chk(req, {24'h0, rdData}, {24'h0, refMem[a]});
    end
  endtask

  // issue a command and follow it cycle by cycle; intrude drives a stray command mid-span
  task automatic issue(logic [AW-1:0] addr, logic [63:0] data, bit intrude, string req);
    logic [3:0]    rop;
    int            base, nBusy;
    logic [7:0]    oldSpan [32];
    rop   = data[63:60];
    base  = int'(addr) & ~31;
    nBusy = (rop == 4'h3) ? 32 : 1;
    for (int j = 0; j < 32; j++) oldSpan[j] = refMem[base + j];
    @(negedge clk);
    chk({req, "/R2 ready"}, {31'h0, cmdReady}, 32'h1);
    cmdValid = 1; cmdAddr = addr; cmdData = data;
    @(negedge clk);
    cmdValid = 0;
    for (int k = 0; k < nBusy; k++) begin
      chk({req, "/R7 busy"}, {31'h0, busy}, 32'h1);
      chk({req, "/R2 ready low"}, {31'h0, cmdReady}, 32'h0);
      if (intrude && k == 3) begin
        cmdValid = 1; cmdAddr = addr ^ 10'h020; cmdData = ~data;
      end
      if (intrude && k == 6) cmdValid = 0;
      if (rop == 4'h3 && k == 10) begin
        // R7: pixels base..base+9 are written, the rest still old
        for (int j = 0; j < 32; j++) begin
          logic [7:0] e;
          e = (j < 10 && data[31 - j]) ? data[39:32] : oldSpan[j];
          rdAddr = AW'(base + j);
          #0.001;
          chk({req, "/R7 mid-span"}, {24'h0, rdData}, {24'h0, e});
        end
      end
      @(negedge clk);
    end
    chk({req, "/R7 busy end"}, {31'h0, busy}, 32'h0);
    if (rop == 4'h3)
      for (int j = 0; j < 32; j++)
        if (data[31 - j]) refMem[base + j] = data[39:32];
    cmpAll({req, "/R6 store"});
  endtask

  initial begin
    #800000;
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) refMem[a] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", {31'h0, busy}, 32'h0);
    chk("R1 ready", {31'h0, cmdReady}, 32'h1);
    cmpAll("R1 store");
    rstN = 1;
    @(negedge clk);

    // R11 + R4: full mask fills the span
    issue(10'h040, mkCmd(4'h3, 2'd0, 8'h5A, 32'hFFFF_FFFF, 2'd0, 16'h0), 0, "R11");
    // R3 + R5: unaligned address, edge bits of the mask
    issue(10'h047, mkCmd(4'h3, 2'd0, 8'hC3, 32'h8000_0001, 2'd0, 16'h0), 0, "R3 R5");
    // R5 + R6: left partial span
    issue(10'h05F, mkCmd(4'h3, 2'd0, 8'h11, 32'hFFFF_0000, 2'd0, 16'h0), 0, "R5 R6");
    // R8: non-copy operation codes
    issue(10'h040, mkCmd(4'h0, 2'd0, 8'hEE, 32'hFFFF_FFFF, 2'd0, 16'h0), 0, "R8 rop0");
    issue(10'h080, mkCmd(4'hF, 2'd0, 8'hEE, 32'hFFFF_FFFF, 2'd0, 16'h0), 0, "R8 ropF");
    // R9: stray command while busy
    issue(10'h100, mkCmd(4'h3, 2'd1, 8'h77, 32'hA5A5_5A5A, 2'd0, 16'h0), 1, "R9");
    // R10: plane selector and unused bits
    issue(10'h120, mkCmd(4'h3, 2'd2, 8'h3C, 32'h0F0F_0F0F, 2'd3, 16'hBEEF), 0, "R10 p2");
    issue(10'h121, mkCmd(4'h3, 2'd3, 8'h9D, 32'hF0F0_F0F0, 2'd1, 16'h1234), 0, "R10 p3");
    // last span in the store, R11
    issue(10'h3FF, mkCmd(4'h3, 2'd0, 8'hFE, 32'hFFFF_FFFF, 2'd0, 16'h0), 0, "R11 top");
    // R6: empty mask
    issue(10'h3E0, mkCmd(4'h3, 2'd0, 8'h01, 32'h0, 2'd0, 16'h0), 0, "R6 empty");

    for (int n = 0; n < 120; n++) begin
      logic [3:0] rop;
      rop = ($urandom % 4 == 0) ? 4'($urandom) : 4'h3;
      issue(AW'($urandom), mkCmd(rop, 2'($urandom), 8'($urandom), $urandom,
            2'($urandom), 16'($urandom)), n % 7 == 0, "R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule